// File: doc/BRIEF.md
# RISC Instruction Decoder with Immediate Extension

This block turns one fixed-width 32-bit RISC instruction word into the fields and control signals that an execute stage needs. It is purely combinational: the register specifiers, the shift amount and the extended immediate are valid in the same cycle as the instruction word, together with the ALU operation, the operand source, the write-back target and the memory access controls.

Three formats share a common field layout. Register formats (major opcode 0) pick their operation through the low function field. Immediate formats carry a 16-bit constant, which is widened to 32 bits. It is sign-extended, zero-extended or moved to the upper half, depending on the opcode. Load signedness, access width and the overflow-trap enable are also taken from the opcode and function code. Any encoding outside the supported set is flagged as illegal, and the flag suppresses every side effect.

Top module: `rvdec_top`

## Requirements
- R1: rs_o equals instruction bits 25:21, rt_o bits 20:16, rd_o bits 15:11 and shamt_o bits 10:6, for every instruction word, legal or not.
- R2: With opcode 0, the function codes 0,2,3,32,33,34,35,36,37,38 give alu_op_o 5 (shift left logical), 6 (shift right logical), 7 (shift right arithmetic), 0 (add), 0, 1 (subtract), 1, 2 (and), 3 (or), 4 (xor). Each sets reg_wr_o=1, dest_rd_o=1, wr_reg_o=rd and alu_src_imm_o=0.
- R3: Opcodes 8 and 9 give alu_op_o 0, opcode 12 gives 2 and opcode 13 gives 3. Each sets reg_wr_o=1, dest_rd_o=0, wr_reg_o=rt and alu_src_imm_o=1. The word 0x21840021 decodes to rs 12, rt 4, immediate 33, destination rt.
- R4: For opcodes 8, 32, 35, 36, 40 and 43, imm_o is the 16-bit constant with bit 15 copied into bits 31:16.
- R5: For opcode 15, imm_o holds the constant in bits 31:16 and zero in bits 15:0. alu_op_o is 8 (pass operand B), alu_src_imm_o=1, reg_wr_o=1 and wr_reg_o=rt.
- R6: For every other opcode, including 9, 12, 13, 0 and illegal ones, imm_o is the constant with bits 31:16 zero.
- R7: Loads (opcode 35 word, 32 signed byte, 36 unsigned byte) set mem_rd_o=1, reg_wr_o=1, wr_reg_o=rt, alu_op_o=0 and alu_src_imm_o=1. mem_byte_o is 1 only for 32 and 36, and ld_unsigned_o is 1 only for 36.
- R8: Stores (opcode 43 word, 40 byte) set mem_wr_o=1, reg_wr_o=0, mem_rd_o=0, alu_op_o=0, alu_src_imm_o=1 and wr_reg_o=rt. mem_byte_o is 1 only for 40.
- R9: ovf_trap_o is 1 exactly for function codes 32 and 34 under opcode 0, and for opcode 8.
- R10: Any other opcode, or opcode 0 with any other function code, sets illegal_o=1. It also clears reg_wr_o, mem_wr_o, mem_rd_o, mem_byte_o, ld_unsigned_o, ovf_trap_o, alu_src_imm_o and dest_rd_o, with alu_op_o=0.
- R11: mem_rd_o and mem_wr_o are never both 1. Instructions that are not loads or stores drive mem_byte_o=0 and ld_unsigned_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rs_o | output | 5 | First source register specifier |
| rt_o | output | 5 | Second source / immediate destination specifier |
| rd_o | output | 5 | Register-format destination specifier |
| shamt_o | output | 5 | Shift amount field |
| wr_reg_o | output | 5 | Selected write-back register |
| dest_rd_o | output | 1 | 1: write-back goes to rd, 0: to rt |
| imm_o | output | 32 | Extended immediate |
| alu_op_o | output | 4 | ALU operation code |
| alu_src_imm_o | output | 1 | Second ALU operand is the immediate |
| reg_wr_o | output | 1 | Register write enable |
| mem_rd_o | output | 1 | Memory read (load) |
| mem_wr_o | output | 1 | Memory write (store) |
| mem_byte_o | output | 1 | Access is one byte (else one word) |
| ld_unsigned_o | output | 1 | Loaded byte is zero-extended |
| ovf_trap_o | output | 1 | Signed overflow trap enabled |
| illegal_o | output | 1 | Instruction not recognised |

## Verification
Hand-built words cover each supported operation with constants that have bit 15 set and clear. This separates sign extension, zero extension and upper placement, which would look alike for small positive values. A full sweep of all 64 opcodes and all 64 function codes, with random register fields, separates the legal set from the illegal one. It also shows that fields are extracted in the same way in both cases. Paired words such as add/addu, lb/lbu and sw/sb differ in only one control output, so a swapped trap, signedness or width bit is exposed directly.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;

   localparam int CODE_W = 6;

   // major opcodes
   localparam logic [CODE_W-1:0] OP_REG   = 6'd0;
   localparam logic [CODE_W-1:0] OP_ADDI  = 6'd8;
   localparam logic [CODE_W-1:0] OP_ADDIU = 6'd9;
   localparam logic [CODE_W-1:0] OP_ANDI  = 6'd12;
   localparam logic [CODE_W-1:0] OP_ORI   = 6'd13;
   localparam logic [CODE_W-1:0] OP_LUI   = 6'd15;
   localparam logic [CODE_W-1:0] OP_LB    = 6'd32;
   localparam logic [CODE_W-1:0] OP_LW    = 6'd35;
   localparam logic [CODE_W-1:0] OP_LBU   = 6'd36;
   localparam logic [CODE_W-1:0] OP_SB    = 6'd40;
   localparam logic [CODE_W-1:0] OP_SW    = 6'd43;

   // function codes under OP_REG
   localparam logic [CODE_W-1:0] FN_SLL  = 6'd0;
   localparam logic [CODE_W-1:0] FN_SRL  = 6'd2;
   localparam logic [CODE_W-1:0] FN_SRA  = 6'd3;
   localparam logic [CODE_W-1:0] FN_ADD  = 6'd32;
   localparam logic [CODE_W-1:0] FN_ADDU = 6'd33;
   localparam logic [CODE_W-1:0] FN_SUB  = 6'd34;
   localparam logic [CODE_W-1:0] FN_SUBU = 6'd35;
   localparam logic [CODE_W-1:0] FN_AND  = 6'd36;
   localparam logic [CODE_W-1:0] FN_OR   = 6'd37;
   localparam logic [CODE_W-1:0] FN_XOR  = 6'd38;

   typedef enum logic [3:0] {
      ALU_ADD  = 4'd0,
      ALU_SUB  = 4'd1,
      ALU_AND  = 4'd2,
      ALU_OR   = 4'd3,
      ALU_XOR  = 4'd4,
      ALU_SLL  = 4'd5,
      ALU_SRL  = 4'd6,
      ALU_SRA  = 4'd7,
      ALU_PASS = 4'd8
   } alu_op_e;

   typedef enum logic [1:0] {
      IMM_ZERO = 2'd0,
      IMM_SIGN = 2'd1,
      IMM_HIGH = 2'd2
   } imm_mode_e;

   typedef struct packed {
      alu_op_e   alu_op;
      imm_mode_e imm_mode;
      logic      alu_src_imm;
      logic      reg_wr;
      logic      dest_rd;
      logic      mem_rd;
      logic      mem_wr;
      logic      mem_byte;
      logic      ld_unsigned;
      logic      ovf_trap;
      logic      illegal;
   } ctrl_t;

endpackage

// File: rtl/rvdec_fields.sv
module rvdec_fields #(
   parameter int INSTR_W = 32,
   parameter int OPC_W   = 6,
   parameter int REG_W   = 5,
   parameter int FN_W    = 6,
   parameter int IMM_W   = 16
) (
   input  logic [INSTR_W-1:0] instr,
   output logic [OPC_W-1:0]   opcode,
   output logic [REG_W-1:0]   rs,
   output logic [REG_W-1:0]   rt,
   output logic [REG_W-1:0]   rd,
   output logic [REG_W-1:0]   shamt,
   output logic [FN_W-1:0]    funct,
   output logic [IMM_W-1:0]   imm
);
   localparam int OPC_LSB = INSTR_W - OPC_W;
   localparam int RS_LSB  = OPC_LSB - REG_W;
   localparam int RT_LSB  = RS_LSB - REG_W;
   localparam int RD_LSB  = RT_LSB - REG_W;
   localparam int SH_LSB  = RD_LSB - REG_W;

   generate
      if (INSTR_W != OPC_W + 2*REG_W + IMM_W) begin : g_bad_split
         $error("instruction width does not match opcode, two specifiers and immediate");
      end
      if (IMM_W != 2*REG_W + FN_W) begin : g_bad_low
         $error("immediate width does not match rd, shamt and function fields");
      end
   endgenerate

   always_comb begin
      opcode = instr[INSTR_W-1 -: OPC_W];
      rs     = instr[RS_LSB +: REG_W];
      rt     = instr[RT_LSB +: REG_W];
      rd     = instr[RD_LSB +: REG_W];
      shamt  = instr[SH_LSB +: REG_W];
      funct  = instr[FN_W-1:0];
      imm    = instr[IMM_W-1:0];
   end
endmodule

// File: rtl/rvdec_ctrl.sv
module rvdec_ctrl
   import rvdec_pkg::*;
#(
   parameter int OPC_W = 6,
   parameter int FN_W  = 6
) (
   input  logic [OPC_W-1:0] opcode,
   input  logic [FN_W-1:0]  funct,
   output ctrl_t            ctrl
);
   generate
      if (OPC_W != CODE_W || FN_W != CODE_W) begin : g_bad_code
         $error("opcode and function widths must match the code table");
      end
   endgenerate

   ctrl_t reg_c;
   ctrl_t imm_c;

   // register format: selected by function field
   always_comb begin
      reg_c         = '0;
      reg_c.alu_op  = ALU_ADD;
      reg_c.imm_mode = IMM_ZERO;
      reg_c.reg_wr  = 1'b1;
      reg_c.dest_rd = 1'b1;
      unique case (funct)
         FN_SLL:  reg_c.alu_op = ALU_SLL;
         FN_SRL:  reg_c.alu_op = ALU_SRL;
         FN_SRA:  reg_c.alu_op = ALU_SRA;
         FN_ADD:  begin reg_c.alu_op = ALU_ADD; reg_c.ovf_trap = 1'b1; end
         FN_ADDU: reg_c.alu_op = ALU_ADD;
         FN_SUB:  begin reg_c.alu_op = ALU_SUB; reg_c.ovf_trap = 1'b1; end
         FN_SUBU: reg_c.alu_op = ALU_SUB;
         FN_AND:  reg_c.alu_op = ALU_AND;
         FN_OR:   reg_c.alu_op = ALU_OR;
         FN_XOR:  reg_c.alu_op = ALU_XOR;
         default: begin
            reg_c         = '0;
            reg_c.alu_op  = ALU_ADD;
            reg_c.imm_mode = IMM_ZERO;
            reg_c.illegal = 1'b1;
         end
      endcase
   end

   // immediate formats: selected by opcode
   always_comb begin
      imm_c             = '0;
      imm_c.alu_op      = ALU_ADD;
      imm_c.imm_mode    = IMM_ZERO;
      imm_c.alu_src_imm = 1'b1;
      unique case (opcode)
         OP_ADDI: begin
            imm_c.reg_wr   = 1'b1;
            imm_c.imm_mode = IMM_SIGN;
            imm_c.ovf_trap = 1'b1;
         end
         OP_ADDIU: imm_c.reg_wr = 1'b1;
         OP_ANDI: begin
            imm_c.reg_wr = 1'b1;
            imm_c.alu_op = ALU_AND;
         end
         OP_ORI: begin
            imm_c.reg_wr = 1'b1;
            imm_c.alu_op = ALU_OR;
         end
         OP_LUI: begin
            imm_c.reg_wr   = 1'b1;
            imm_c.alu_op   = ALU_PASS;
            imm_c.imm_mode = IMM_HIGH;
         end
         OP_LW: begin
            imm_c.reg_wr   = 1'b1;
            imm_c.mem_rd   = 1'b1;
            imm_c.imm_mode = IMM_SIGN;
         end
         OP_LB: begin
            imm_c.reg_wr   = 1'b1;
            imm_c.mem_rd   = 1'b1;
            imm_c.mem_byte = 1'b1;
            imm_c.imm_mode = IMM_SIGN;
         end
         OP_LBU: begin
            imm_c.reg_wr      = 1'b1;
            imm_c.mem_rd      = 1'b1;
            imm_c.mem_byte    = 1'b1;
            imm_c.ld_unsigned = 1'b1;
            imm_c.imm_mode    = IMM_SIGN;
         end
         OP_SW: begin
            imm_c.mem_wr   = 1'b1;
            imm_c.imm_mode = IMM_SIGN;
         end
         OP_SB: begin
            imm_c.mem_wr   = 1'b1;
            imm_c.mem_byte = 1'b1;
            imm_c.imm_mode = IMM_SIGN;
         end
         default: begin
            imm_c.alu_src_imm = 1'b0;
            imm_c.illegal     = 1'b1;
         end
      endcase
   end

   // format select, then side effects squashed for illegal words
   always_comb begin
      ctrl = (opcode == OP_REG) ? reg_c : imm_c;
      if (ctrl.illegal) begin
         ctrl             = '0;
         ctrl.alu_op      = ALU_ADD;
         ctrl.imm_mode    = IMM_ZERO;
         ctrl.illegal     = 1'b1;
      end
   end
endmodule

// File: rtl/rvdec_immext.sv
module rvdec_immext
   import rvdec_pkg::*;
#(
   parameter int IMM_W  = 16,
   parameter int DATA_W = 32
) (
   input  logic [IMM_W-1:0]  imm,
   input  imm_mode_e         mode,
   output logic [DATA_W-1:0] value
);
   localparam int FILL_W = DATA_W - IMM_W;

   logic [FILL_W-1:0] fill;
   logic [DATA_W-1:0] high_val;

   generate
      if (DATA_W <= IMM_W) begin : g_bad_width
         $error("data width must exceed immediate width");
      end

      // upper fill bits: copy of the constant sign bit when signed
      for (genvar i = 0; i < FILL_W; i++) begin : g_fill
         assign fill[i] = (mode == IMM_SIGN) & imm[IMM_W-1];
      end

      // upper placement variant depends on room above the constant
      if (FILL_W >= IMM_W) begin : g_high_wide
         assign high_val = {imm, {(DATA_W-IMM_W){1'b0}}};
      end else begin : g_high_narrow
         assign high_val = {imm[FILL_W-1:0], {IMM_W{1'b0}}};
      end
   endgenerate

   always_comb begin
      if (mode == IMM_HIGH) value = high_val;
      else                  value = {fill, imm};
   end
endmodule

// File: rtl/rvdec_top.sv
module rvdec_top
   import rvdec_pkg::*;
#(
   parameter int INSTR_W = 32,
   parameter int OPC_W   = 6,
   parameter int REG_W   = 5,
   parameter int FN_W    = 6,
   parameter int IMM_W   = 16,
   parameter int DATA_W  = 32
) (
   input  logic [INSTR_W-1:0] instr_i,
   output logic [REG_W-1:0]   rs_o,
   output logic [REG_W-1:0]   rt_o,
   output logic [REG_W-1:0]   rd_o,
   output logic [REG_W-1:0]   shamt_o,
   output logic [REG_W-1:0]   wr_reg_o,
   output logic               dest_rd_o,
   output logic [DATA_W-1:0]  imm_o,
   output logic [3:0]         alu_op_o,
   output logic               alu_src_imm_o,
   output logic               reg_wr_o,
   output logic               mem_rd_o,
   output logic               mem_wr_o,
   output logic               mem_byte_o,
   output logic               ld_unsigned_o,
   output logic               ovf_trap_o,
   output logic               illegal_o
);
   logic [OPC_W-1:0] opcode;
   logic [FN_W-1:0]  funct;
   logic [IMM_W-1:0] imm_raw;
   ctrl_t            ctrl;

   rvdec_fields #(
      .INSTR_W(INSTR_W), .OPC_W(OPC_W), .REG_W(REG_W), .FN_W(FN_W), .IMM_W(IMM_W)
   ) fields_i (
      .instr  (instr_i),
      .opcode (opcode),
      .rs     (rs_o),
      .rt     (rt_o),
      .rd     (rd_o),
      .shamt  (shamt_o),
      .funct  (funct),
      .imm    (imm_raw)
   );

   rvdec_ctrl #(.OPC_W(OPC_W), .FN_W(FN_W)) ctrl_i (
      .opcode (opcode),
      .funct  (funct),
      .ctrl   (ctrl)
   );

   rvdec_immext #(.IMM_W(IMM_W), .DATA_W(DATA_W)) immext_i (
      .imm   (imm_raw),
      .mode  (ctrl.imm_mode),
      .value (imm_o)
   );

   always_comb begin
      wr_reg_o      = ctrl.dest_rd ? rd_o : rt_o;
      dest_rd_o     = ctrl.dest_rd;
      alu_op_o      = ctrl.alu_op;
      alu_src_imm_o = ctrl.alu_src_imm;
      reg_wr_o      = ctrl.reg_wr;
      mem_rd_o      = ctrl.mem_rd;
      mem_wr_o      = ctrl.mem_wr;
      mem_byte_o    = ctrl.mem_byte;
      ld_unsigned_o = ctrl.ld_unsigned;
      ovf_trap_o    = ctrl.ovf_trap;
      illegal_o     = ctrl.illegal;
   end
endmodule

// File: rtl/rvdec_chk.sv
module rvdec_chk #(
   parameter int INSTR_W = 32,
   parameter int REG_W   = 5,
   parameter int DATA_W  = 32
) (
   input logic [INSTR_W-1:0] instr_i,
   input logic [REG_W-1:0]   rd_o,
   input logic [REG_W-1:0]   rt_o,
   input logic [REG_W-1:0]   wr_reg_o,
   input logic [DATA_W-1:0]  imm_o,
   input logic               reg_wr_o,
   input logic               mem_rd_o,
   input logic               mem_wr_o,
   input logic               mem_byte_o,
   input logic               ld_unsigned_o,
   input logic               ovf_trap_o,
   input logic               illegal_o
);
   logic [5:0] opc;
   assign opc = instr_i[31:26];

   always_comb begin
      AST_ILLEGAL_QUIET: assert (!illegal_o || (!reg_wr_o && !mem_wr_o && !mem_rd_o))
         else $error("illegal word with side effect"); // R10
      AST_MEM_EXCL: assert (!(mem_rd_o && mem_wr_o))
         else $error("read and write together"); // R11
      AST_BYTE_NEEDS_MEM: assert (!(mem_byte_o || ld_unsigned_o) || mem_rd_o || mem_wr_o)
         else $error("width/sign set without access"); // R11
      AST_STORE_NO_WB: assert (!mem_wr_o || !reg_wr_o)
         else $error("store writes a register"); // R8
      AST_UPPER_LOW_ZERO: assert (illegal_o || opc != 6'd15 || imm_o == {instr_i[15:0], 16'h0})
         else $error("upper immediate misplaced"); // R5
      AST_SIGNED_FILL: assert (opc != 6'd8 || imm_o[31:16] == {16{instr_i[15]}})
         else $error("signed fill wrong"); // R4
      AST_REG_DEST: assert (!reg_wr_o || (opc == 6'd0 ? wr_reg_o == rd_o : wr_reg_o == rt_o))
         else $error("destination select wrong"); // R2
      AST_TRAP_ONLY_SIGNED: assert (!ovf_trap_o || (reg_wr_o && (opc == 6'd0 || opc == 6'd8)))
         else $error("trap on wrong instruction"); // R9
   end
endmodule

bind rvdec_top rvdec_chk chk_i (.*);

// File: tb/rvdec_top_tb_top.sv
module rvdec_top_tb_top;

   typedef struct packed {
      logic [4:0]  rs, rt, rd, sh, wr;
      logic        dst;
      logic [31:0] imm;
      logic [3:0]  alu;
      logic        src, rw, mr, mw, mb, lu, ov, il;
   } obs_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr_i = '0;

   logic [4:0]  rs_o, rt_o, rd_o, shamt_o, wr_reg_o;
   logic        dest_rd_o;
   logic [31:0] imm_o;
   logic [3:0]  alu_op_o;
   logic        alu_src_imm_o, reg_wr_o, mem_rd_o, mem_wr_o;
   logic        mem_byte_o, ld_unsigned_o, ovf_trap_o, illegal_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   obs_t  exp_q[$];
   string tag_q[$];

   always #2.5 clk = ~clk;

   rvdec_top dut_i (.*);

   function automatic obs_t model(input logic [31:0] w);
      obs_t e;
      logic [5:0] op, fn;
      op = w[31:26];
      fn = w[5:0];
      e = '0;
      e.rs = w[25:21]; e.rt = w[20:16]; e.rd = w[15:11]; e.sh = w[10:6];
      e.imm = {16'h0, w[15:0]};                                   // R6 default
      if (op == 8 || op == 32 || op == 35 || op == 36 || op == 40 || op == 43)
         e.imm = {{16{w[15]}}, w[15:0]};                          // R4
      if (op == 15) e.imm = {w[15:0], 16'h0};                     // R5
      if (op == 0) begin
         e.rw = 1; e.dst = 1;
         if      (fn == 0)  e.alu = 5;
         else if (fn == 2)  e.alu = 6;
         else if (fn == 3)  e.alu = 7;
         else if (fn == 32) begin e.alu = 0; e.ov = 1; end
         else if (fn == 33) e.alu = 0;
         else if (fn == 34) begin e.alu = 1; e.ov = 1; end
         else if (fn == 35) e.alu = 1;
         else if (fn == 36) e.alu = 2;
         else if (fn == 37) e.alu = 3;
         else if (fn == 38) e.alu = 4;
         else begin e.rw = 0; e.dst = 0; e.il = 1; end
      end else if (op == 8 || op == 9 || op == 12 || op == 13 || op == 15) begin
         e.rw = 1; e.src = 1;
         e.alu = (op == 12) ? 4'd2 : (op == 13) ? 4'd3 : (op == 15) ? 4'd8 : 4'd0;
         e.ov = (op == 8);
      end else if (op == 32 || op == 35 || op == 36) begin
         e.rw = 1; e.src = 1; e.mr = 1;
         e.mb = (op != 35); e.lu = (op == 36);
      end else if (op == 40 || op == 43) begin
         e.src = 1; e.mw = 1; e.mb = (op == 40);
      end else begin
         e.il = 1;
      end
      e.wr = e.dst ? e.rd : e.rt;
      return e;
   endfunction

   function automatic string tag_of(input logic [31:0] w);
      logic [5:0] op;
      op = w[31:26];
      if (op == 0) begin
         if (w[5:0] == 32 || w[5:0] == 34) return "R2/R9";
         return "R2/R10";
      end
      if (op == 8) return "R3/R4/R9";
      if (op == 9 || op == 12 || op == 13) return "R3/R6";
      if (op == 15) return "R5";
      if (op == 32 || op == 35 || op == 36) return "R7/R11";
      if (op == 40 || op == 43) return "R8/R11";
      return "R10/R1";
   endfunction

   task automatic drive(input logic [31:0] w, input string tag);
      @(posedge clk);
      instr_i = w;
      exp_q.push_back(model(w));
      tag_q.push_back(tag);
   endtask

   function automatic logic [31:0] ri(input logic [5:0] op, input logic [4:0] rs,
                                      input logic [4:0] rt, input logic [15:0] k);
      return {op, rs, rt, k};
   endfunction

   function automatic logic [31:0] rr(input logic [4:0] rs, input logic [4:0] rt,
                                      input logic [4:0] rd, input logic [4:0] sh,
                                      input logic [5:0] fn);
      return {6'd0, rs, rt, rd, sh, fn};
   endfunction

   // monitor: compare one scoreboard item per cycle at the falling edge
   initial begin
      obs_t a, e;
      string t;
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = '{rs: rs_o, rt: rt_o, rd: rd_o, sh: shamt_o, wr: wr_reg_o,
                  dst: dest_rd_o, imm: imm_o, alu: alu_op_o, src: alu_src_imm_o,
                  rw: reg_wr_o, mr: mem_rd_o, mw: mem_wr_o, mb: mem_byte_o,
                  lu: ld_unsigned_o, ov: ovf_trap_o, il: illegal_o};
            checks++;
            if (a !== e) begin
               errors++;
               $display("FAIL %s instr=%h actual=%h expected=%h", t, instr_i, a, e);
            end
         end
      end
   end

   // driver
   initial begin
      drive(32'h0, "reset R2 R1");                      // state seen during reset
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      drive(32'h21840021, "R3 example");                // rs 12, rt 4, imm 33
      drive(rr(5'd8, 5'd9, 5'd7, 5'd0, 6'd34), "R2 R9 sub");
      drive(rr(5'd8, 5'd9, 5'd7, 5'd0, 6'd35), "R2 R9 subu no trap");
      drive(rr(5'd1, 5'd5, 5'd6, 5'd3, 6'd3), "R2 R1 sra shamt");
      drive(ri(6'd8,  5'd3, 5'd4, 16'h8000), "R4 R9 addi negative");
      drive(ri(6'd9,  5'd3, 5'd4, 16'hFFFF), "R6 addiu zero fill");
      drive(ri(6'd12, 5'd2, 5'd9, 16'hF0F0), "R6 andi");
      drive(ri(6'd13, 5'd6, 5'd6, 16'h8001), "R6 ori");
      drive(ri(6'd15, 5'd0, 5'd8, 16'h1B23), "R5 lui");
      drive(ri(6'd15, 5'd0, 5'd8, 16'hFFFF), "R5 lui high bit");
      drive(ri(6'd35, 5'd29, 5'd14, 16'h0008), "R7 lw");
      drive(ri(6'd32, 5'd4, 5'd5, 16'hFFFC), "R7 lb signed");
      drive(ri(6'd36, 5'd4, 5'd5, 16'hFFFC), "R7 lbu unsigned");
      drive(ri(6'd43, 5'd7, 5'd2, 16'h8004), "R8 sw");
      drive(ri(6'd40, 5'd7, 5'd2, 16'h0001), "R8 sb");
      drive(rr(5'd1, 5'd2, 5'd3, 5'd0, 6'd1), "R10 bad function");
      drive(ri(6'd2, 5'd31, 5'd31, 16'hFFFF), "R10 R11 bad opcode");
      // sweep every opcode with random fields
      for (int op = 0; op < 64; op++) begin
         logic [31:0] w;
         w = $urandom;
         w[31:26] = op[5:0];
         drive(w, tag_of(w));
      end
      // sweep every function code
      for (int fn = 0; fn < 64; fn++) begin
         logic [31:0] w;
         w = $urandom;
         w[31:26] = 6'd0;
         w[5:0] = fn[5:0];
         drive(w, tag_of(w));
      end
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule